// File: doc/BRIEF.md
# RMII Transmit Framer

This block turns an outgoing Ethernet frame into the two-bit symbol stream of a reduced media independent interface. The frame arrives as a byte stream with a valid/ready handshake and a last marker. It carries the destination address through the end of the payload, with no check sequence. The block wraps the bytes in a start pattern, sends them two bits per symbol, computes and appends the 32-bit frame check sequence, and then holds the line idle for a fixed gap. It drives the two data pins and the transmit enable. The symbol rate comes from an external one-cycle enable strobe, so the block itself runs on a faster system clock. All symbol outputs change only on clock edges where the strobe is high.

The controller is a state machine with six states. IDLE waits for a frame to be offered. PREAMBLE sends the 31 sync symbols. SFD sends the delimiter symbol and takes the first byte. DATA serializes bytes and takes the next byte at each byte boundary. FCS sends the 16 check symbols. GAP holds the line idle.

The transitions are as follows. IDLE goes to PREAMBLE on a strobe with valid high. PREAMBLE goes to SFD after its last sync symbol. SFD goes to DATA when a byte is taken, or to GAP on underrun. DATA goes to FCS after the last byte, or to GAP on a short frame, an overlength frame or an underrun. FCS goes to GAP after its 16th symbol. GAP goes to PREAMBLE if a new frame is already waiting when the gap ends, and to IDLE otherwise.

Two sticky flags, one for a length error and one for underrun, report refused or broken frames. Both stay set until the next frame begins.

Top module: `rmii_tx_framer`

## Requirements
- R1: A frame opens with 31 symbols of tx_en=1 and txd=2'b01 (txd[0] is the bit sent first and is 1).
- R2: The 32nd symbol is a single delimiter symbol with tx_en=1 and txd=2'b11.
- R3: Each byte goes out as four symbols with tx_en=1, in the order bits [1:0], [3:2], [5:4], [7:6], where byte bit 2k maps to txd[0]. tx_en and txd change only on edges where sym_en is high.
- R4: The check value is a CRC-32 over all frame bytes, taken LSB first, using the reflected polynomial 32'hEDB88320, preset to all ones and inverted at the end.
- R5: The check value is sent as four bytes, lowest byte first, each serialized as in R3, for 16 symbols in total. tx_en goes low on the next symbol.
- R6: After each frame exactly 48 symbols with tx_en=0 and txd=2'b00 are sent before the next preamble can begin. When a frame is already waiting, its preamble starts on the 49th symbol.
- R7: A frame whose last byte arrives at a count below MIN_LEN (60) is short. Its bytes are sent but no check value follows, and len_err is set.
- R8: A frame of exactly MAX_LEN (1518) bytes is sent normally. If the 1518th byte is not marked last, no further byte is accepted, tx_en drops after that byte's fourth symbol, and len_err is set.
- R9: in_ready is high only in a symbol period where a byte is due: the delimiter symbol, or the fourth symbol of a byte that is not the last. Exactly one byte is taken per frame byte, and in_ready is low during the preamble, the check value and the gap.
- R10: If in_valid is low when a byte is due, the frame is aborted: tx_en drops on the next symbol, underrun is set, and the gap follows.
- R11: After reset tx_en, txd, in_ready, len_err and underrun are all 0. Each flag stays set until the next preamble starts, when both are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_en | input | 1 | One-cycle strobe marking each symbol boundary |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Byte on in_data is valid |
| in_last | input | 1 | Byte is the final byte of the frame |
| in_ready | output | 1 | Byte is taken on this edge if in_valid is high |
| txd | output | 2 | Transmit dibit, txd[0] sent first |
| tx_en | output | 1 | Transmit enable |
| len_err | output | 1 | Sticky: last frame was too short or too long |
| underrun | output | 1 | Sticky: last frame was aborted for lack of data |

## Verification
Frames of minimum length and of a slightly larger length are sent with a symbol strobe on every cycle and on every third cycle. Every recorded symbol is compared against preamble, delimiter, data and check sequences computed in the bench. This separates bit-order errors, CRC errors and strobe-gating errors. Two frames back to back measure the idle gap exactly. Frames at 59, 1518 and 1519 bytes probe both length limits by counting enabled symbols. A frame that starves mid-stream, followed by a clean frame, shows both the abort and the clearing of the flags.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD,
        ST_DATA,
        ST_FCS,
        ST_GAP
    } tx_state_t;

    localparam logic [31:0] FCS_POLY = 32'hEDB88320;
    localparam int          FCS_SYMS = 16;

    // one byte of reflected CRC-32, LSB of the byte first
    function automatic logic [31:0] fcs_next(input logic [31:0] cur, input logic [7:0] b);
        logic [31:0] c;
        c = cur ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ FCS_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rmii_fcs_acc.sv
module rmii_fcs_acc
    import rmii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd,
    input  logic        restart,
    input  logic [7:0]  data,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= fcs_next(restart ? 32'hFFFF_FFFF : crc_q, data);
        end
    end

    assign fcs = ~crc_q;

    AST_RESTART_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> upd); // R4

endmodule

// File: rtl/rmii_dibit_shreg.sv
module rmii_dibit_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic [1:0]       dibit
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= q >> 2;
        end
    end

    assign dibit = q[1:0];

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R3

endmodule

// File: rtl/rmii_tx_framer.sv
module rmii_tx_framer
    import rmii_tx_pkg::*;
#(
    parameter int MIN_LEN  = 60,
    parameter int MAX_LEN  = 1518,
    parameter int PRE_SYMS = 31,
    parameter int GAP_SYMS = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_en,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [1:0] txd,
    output logic       tx_en,
    output logic       len_err,
    output logic       underrun
);
    localparam int CNT_MAX = (GAP_SYMS > PRE_SYMS) ? GAP_SYMS : PRE_SYMS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BC_W    = $clog2(MAX_LEN + 1);

    tx_state_t        st, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       dib_q;
    logic [BC_W-1:0]  byte_cnt, byte_cnt_nx;
    logic             last_q, short_q;
    logic             cnt_clr, cnt_inc, accept, start;
    logic             set_len, set_und, d_shift, f_load, f_shift, byte_slot;
    logic [1:0]       d_dibit, f_dibit;
    logic [31:0]      fcs_val;

    // next-state and control
    always_comb begin
        nxt       = st;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        start     = 1'b0;
        set_len   = 1'b0;
        set_und   = 1'b0;
        d_shift   = 1'b0;
        f_load    = 1'b0;
        f_shift   = 1'b0;
        byte_slot = (st == ST_DATA) && (dib_q == 2'd3) && !last_q;
        in_ready  = sym_en && ((st == ST_SFD) ||
                    (byte_slot && (byte_cnt < BC_W'(MAX_LEN))));
        accept    = in_ready && in_valid;
        byte_cnt_nx = (st == ST_SFD) ? BC_W'(1) : byte_cnt + 1'b1;
        if (sym_en) begin
            unique case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        nxt = ST_PREAMBLE; start = 1'b1; cnt_clr = 1'b1;
                    end
                end
                ST_PREAMBLE: begin
                    if (cnt_q == CNT_W'(PRE_SYMS - 1)) begin
                        nxt = ST_SFD; cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_SFD: begin
                    if (in_valid) begin
                        nxt = ST_DATA;
                    end else begin
                        nxt = ST_GAP; set_und = 1'b1; cnt_clr = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (dib_q != 2'd3) begin
                        d_shift = 1'b1;
                    end else if (last_q) begin
                        nxt = short_q ? ST_GAP : ST_FCS;
                        f_load = !short_q;
                        cnt_clr = 1'b1;
                    end else if (byte_cnt == BC_W'(MAX_LEN)) begin
                        nxt = ST_GAP; set_len = 1'b1; cnt_clr = 1'b1;
                    end else if (!in_valid) begin
                        nxt = ST_GAP; set_und = 1'b1; cnt_clr = 1'b1;
                    end
                end
                ST_FCS: begin
                    f_shift = 1'b1;
                    if (cnt_q == CNT_W'(FCS_SYMS - 1)) begin
                        nxt = ST_GAP; cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == CNT_W'(GAP_SYMS - 1)) begin
                        cnt_clr = 1'b1;
                        if (in_valid) begin
                            nxt = ST_PREAMBLE; start = 1'b1;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register and per-frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt_q    <= '0;
            dib_q    <= '0;
            byte_cnt <= '0;
            last_q   <= 1'b0;
            short_q  <= 1'b0;
            len_err  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            st <= nxt;
            if (cnt_clr)      cnt_q <= '0;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
            if (accept)                          dib_q <= '0;
            else if (sym_en && st == ST_DATA)    dib_q <= dib_q + 1'b1;
            if (start) begin
                byte_cnt <= '0;
                last_q   <= 1'b0;
                short_q  <= 1'b0;
                len_err  <= 1'b0;
                underrun <= 1'b0;
            end else begin
                if (accept) begin
                    byte_cnt <= byte_cnt_nx;
                    last_q   <= in_last;
                    short_q  <= in_last && (byte_cnt_nx < BC_W'(MIN_LEN));
                    if (in_last && (byte_cnt_nx < BC_W'(MIN_LEN))) len_err <= 1'b1;
                end
                if (set_len) len_err  <= 1'b1;
                if (set_und) underrun <= 1'b1;
            end
        end
    end

    rmii_fcs_acc u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (accept),
        .restart (accept && (st == ST_SFD)),
        .data    (in_data),
        .fcs     (fcs_val)
    );

    rmii_dibit_shreg #(.WIDTH(8)) u_data_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (in_data),
        .shift    (d_shift),
        .dibit    (d_dibit)
    );

    rmii_dibit_shreg #(.WIDTH(32)) u_fcs_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (f_load),
        .load_val (fcs_val),
        .shift    (f_shift),
        .dibit    (f_dibit)
    );

    // outputs
    always_comb begin
        tx_en = 1'b0;
        txd   = 2'b00;
        unique case (st)
            ST_PREAMBLE: begin tx_en = 1'b1; txd = 2'b01;   end
            ST_SFD:      begin tx_en = 1'b1; txd = 2'b11;   end
            ST_DATA:     begin tx_en = 1'b1; txd = d_dibit; end
            ST_FCS:      begin tx_en = 1'b1; txd = f_dibit; end
            default:     begin tx_en = 1'b0; txd = 2'b00;   end
        endcase
    end

    AST_OPENS_WITH_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 2'b01)); // R1
    AST_HOLD_BETWEEN_SYMS: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> ($stable(tx_en) && $stable(txd))); // R3
    AST_NO_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready); // R9
    AST_ABORT_DROPS_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !tx_en); // R10
    AST_FLAGS_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (!underrun && !len_err)); // R11

endmodule

// File: tb/tb_rmii_tx_framer.sv
module tb_rmii_tx_framer;
    localparam int LOG_N = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_en = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [1:0] txd;
    logic       tx_en;
    logic       len_err;
    logic       underrun;

    rmii_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .txd(txd), .tx_en(tx_en), .len_err(len_err), .underrun(underrun)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int div     = 1;
    int ph      = 0;

    logic [2:0] sym_log [LOG_N];
    int rec_len   = 0;
    int en_cnt    = 0;
    int acc_cnt   = 0;
    int bad_ready = 0;
    int idle_run  = 0;
    int last_gap  = -1;
    logic prev_en = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        ph = (ph + 1 >= div) ? 0 : ph + 1;
        sym_en = (ph == 0);
    end

    always @(negedge clk) begin
        #5;
        if (in_ready && in_valid) acc_cnt++;
        if (in_ready && !tx_en) bad_ready++;
        if (sym_en) begin
            if (rec_len < LOG_N) sym_log[rec_len] = {tx_en, txd};
            rec_len++;
            if (tx_en) begin
                en_cnt++;
                if (!prev_en) last_gap = idle_run;
                idle_run = 0;
            end else begin
                idle_run++;
            end
            prev_en = tx_en;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'((i * 37) + (seed * 11) + (i >> 3));
    endfunction

    function automatic logic [31:0] exp_fcs(input int n, input int seed);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, byte_of(seed, i)};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [2:0] get_sym(input int i);
        if (i < 0 || i >= LOG_N || i >= rec_len) return 3'b010;
        return sym_log[i];
    endfunction

    task automatic rec_clear();
        rec_len = 0; en_cnt = 0; acc_cnt = 0; bad_ready = 0;
    endtask

    task automatic send_frame(input int n, input int seed, input int stop_at,
                              input int max_wait, output bit refused);
        refused = 1'b0;
        for (int i = 0; i < n; i++) begin
            int w;
            if (i == stop_at) break;
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = byte_of(seed, i);
            in_last  = (i == n - 1);
            #1;
            w = 0;
            while (!in_ready && w < max_wait) begin
                @(negedge clk); #1; w++;
            end
            if (!in_ready) begin
                refused = 1'b1;
                break;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (90 * div) @(negedge clk);
    endtask

    task automatic check_frame(input int n, input int seed, input bit with_fcs);
        int s = -1;
        int bad;
        int k;
        logic [7:0] bv;
        logic [31:0] f;
        for (int i = 0; i < LOG_N && i < rec_len; i++) if (s < 0 && sym_log[i][2]) s = i;
        chk(s >= 0, "R1 frame start found", s, 0);
        bad = 0;
        for (int i = 0; i < 31; i++) if (get_sym(s + i) != 3'b101) bad++;
        chk(bad == 0, "R1 preamble symbols", bad, 0);
        chk(get_sym(s + 31) == 3'b111, "R2 delimiter symbol", get_sym(s + 31), 3'b111);
        bad = 0;
        for (int b = 0; b < n; b++) begin
            bv = byte_of(seed, b);
            for (int d = 0; d < 4; d++)
                if (get_sym(s + 32 + 4 * b + d) != {1'b1, bv[2 * d +: 2]}) bad++;
        end
        chk(bad == 0, "R3 data dibits", bad, 0);
        k = s + 32 + 4 * n;
        if (with_fcs) begin
            f = exp_fcs(n, seed);
            bad = 0;
            for (int j = 0; j < 16; j++) if (get_sym(k + j) != {1'b1, f[2 * j +: 2]}) bad++;
            chk(bad == 0, "R4 R5 check sequence", bad, 0);
            k = k + 16;
        end
        chk(get_sym(k) == 3'b000, "R5 line idle after frame", get_sym(k), 0);
    endtask

    task automatic t_reset();
        chk(tx_en == 1'b0 && txd == 2'b00, "R11 reset outputs", {tx_en, txd}, 0);
        chk(in_ready == 1'b0, "R11 reset ready", in_ready, 0);
        chk(len_err == 1'b0 && underrun == 1'b0, "R11 reset flags", {len_err, underrun}, 0);
    endtask

    task automatic t_basic(input int n, input int d, input int seed);
        bit r;
        div = d;
        rec_clear();
        send_frame(n, seed, -1, 3000, r);
        settle();
        check_frame(n, seed, 1'b1);
        chk(acc_cnt == n, "R9 one handshake per byte", acc_cnt, n);
        chk(bad_ready == 0, "R9 no ready while idle", bad_ready, 0);
        chk(len_err == 1'b0, "R8 no length error", len_err, 0);
    endtask

    task automatic t_back2back();
        bit r;
        div = 1;
        rec_clear();
        send_frame(60, 3, -1, 3000, r);
        send_frame(61, 4, -1, 3000, r);
        settle();
        chk(last_gap == 48, "R6 idle gap between frames", last_gap, 48);
    endtask

    task automatic t_short();
        bit r;
        div = 1;
        rec_clear();
        send_frame(59, 5, -1, 3000, r);
        settle();
        chk(len_err == 1'b1, "R7 short frame flagged", len_err, 1);
        chk(en_cnt == 32 + 4 * 59, "R7 no check sequence", en_cnt, 32 + 4 * 59);
        check_frame(59, 5, 1'b0);
    endtask

    task automatic t_max();
        bit r;
        div = 1;
        rec_clear();
        send_frame(1518, 6, -1, 3000, r);
        settle();
        chk(len_err == 1'b0, "R8 max frame accepted", len_err, 0);
        chk(en_cnt == 32 + 4 * 1518 + 16, "R8 max frame symbols", en_cnt, 32 + 4 * 1518 + 16);
    endtask

    task automatic t_long();
        bit r;
        div = 1;
        rec_clear();
        send_frame(1519, 7, -1, 40, r);
        settle();
        chk(r == 1'b1, "R8 extra byte refused", r, 1);
        chk(len_err == 1'b1, "R8 long frame flagged", len_err, 1);
        chk(en_cnt == 32 + 4 * 1518, "R8 enable drops after limit", en_cnt, 32 + 4 * 1518);
    endtask

    task automatic t_underrun();
        bit r;
        div = 1;
        rec_clear();
        send_frame(20, 8, 10, 3000, r);
        settle();
        chk(underrun == 1'b1, "R10 underrun flagged", underrun, 1);
        chk(en_cnt == 32 + 40, "R10 frame cut after data stops", en_cnt, 72);
        chk(tx_en == 1'b0, "R10 line idle", tx_en, 0);
        repeat (200) @(negedge clk);
        chk(underrun == 1'b1, "R11 flag held", underrun, 1);
    endtask

    task automatic t_clear();
        bit r;
        div = 1;
        rec_clear();
        send_frame(60, 9, -1, 3000, r);
        settle();
        chk(underrun == 1'b0 && len_err == 1'b0, "R11 flags cleared by new frame",
            {len_err, underrun}, 0);
        check_frame(60, 9, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_basic(60, 1, 1);
        t_basic(64, 3, 2);
        t_back2back();
        t_short();
        t_max();
        t_long();
        t_underrun();
        t_clear();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule